// File: doc/BRIEF.md
# Dual-Clock Mailbox Register With Flag

This block is a single-word side channel that runs next to a FIFO but does not go through it. A producer in the writer clock domain drops one 36-bit word into the mailbox. A consumer in the reader clock domain collects it later. An active-low full flag tells both sides whether the mailbox holds a word that has not yet been read. The reader has one output register. A select pin chooses what that register loads on each read: the mailbox word, or the word the neighbouring FIFO presents.

The writer side uses a valid/ready style. `wr_full_n` is the ready signal. A write is taken only on a clock edge where `wr_valid`, `wr_mbx_sel` and `wr_full_n` are all high. A word offered while `wr_full_n` is low is dropped, not held. The producer must keep the word and offer it again after the flag rises. A word offered with `wr_mbx_sel` low belongs to the FIFO path and is ignored here. On the reader side, every `rd_en` edge loads `rd_data` and raises `rd_data_valid` for one cycle. There is no back-pressure on the reader.

Each side has its own view of the flag. A write event and a read acknowledge each toggle a token register. The other side samples that token through a two-flop synchronizer. The mailbox word is not synchronized: it cannot change between the write and the moment the writer learns of the read. A master reset or a partial reset empties the mailbox and clears the reader output register. Only the master reset also clears the stored word.

Top module: `mbx_mailbox_top`

## Requirements
- R1: On a writer clock edge with `wr_valid`, `wr_mbx_sel` and `wr_full_n` all high, the block stores `wr_data`, and `wr_full_n` is low after that edge.
- R2: A write offered while `wr_full_n` is low, or with `wr_mbx_sel` low, changes neither the stored word nor `wr_full_n`.
- R3: A reader edge with `rd_en` and `rd_mbx_sel` high while `rd_full_n` is low leaves `rd_full_n` high after that edge. A read with `rd_mbx_sel` low leaves `rd_full_n` unchanged.
- R4: On every reader edge with `rd_en` high, `rd_data` loads the stored word when `rd_mbx_sel` is high and `fifo_word` when it is low. `rd_data_valid` is high in exactly the cycles that follow such an edge.
- R5: A mailbox read while `rd_full_n` is high returns the last stored word and leaves both flags high.
- R6: After a master or partial reset, `wr_full_n` and `rd_full_n` are high, `rd_data` is zero and `rd_data_valid` is low.
- R7: After an accepted write, `rd_full_n` falls by the third reader edge. After a read acknowledge, `wr_full_n` rises by the third writer edge.
- R8: A partial reset keeps the stored word, so a later mailbox read returns it.
- R9: A master reset clears the stored word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Writer clock |
| clk_r | input | 1 | Reader clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| prst_n | input | 1 | Partial reset, active low, asynchronous |
| wr_valid | input | 1 | Writer offers a word |
| wr_mbx_sel | input | 1 | High: the offered word is for the mailbox |
| wr_data | input | 36 | Offered word |
| wr_full_n | output | 1 | Writer view of flag; high means a write will be taken |
| rd_en | input | 1 | Reader loads its output register |
| rd_mbx_sel | input | 1 | High: load the mailbox; low: load `fifo_word` |
| fifo_word | input | 36 | Word from the neighbouring FIFO |
| rd_data | output | 36 | Reader output register |
| rd_data_valid | output | 1 | High for one cycle after each `rd_en` edge |
| rd_full_n | output | 1 | Reader view of flag; low means an unread word is waiting |

## Verification
The hardest situations to reach from the ports are those that hinge on a flag view that lags by a synchronizer. One is a second write arriving while the writer's flag is still low. Another is a mailbox read issued after the reader has already seen the mailbox empty. The stimulus offers a second word right after a write is accepted and checks later that the first word survived. It reads again after the acknowledge to get the stale word back. The two clocks have periods with no common edge, and every flag transition is timed in edges of the observing clock. Resets are pulsed while the mailbox is full, so the partial and master cases can be told apart by the word a later stale read returns.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic {
    SRC_FIFO = 1'b0,
    SRC_MBX  = 1'b1
  } rd_src_e;

  // one side owns each token; the mailbox is occupied when they disagree
  function automatic logic tokens_pending(input logic put_tok, input logic ack_tok);
    return put_tok ^ ack_tok;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];
endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mbx_wr_side.sv
module mbx_wr_side #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_rst_n,
  input  logic              wr_valid,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ack_tok_async,
  output logic              full_n,
  output logic              put_tok,
  output logic [DATA_W-1:0] mbx_word
);
  import mbx_pkg::*;

  logic ack_seen;
  logic occupied;
  logic accept;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_tok_async),
    .q    (ack_seen)
  );

  assign occupied = tokens_pending(put_tok, ack_seen);
  assign accept   = rst_n & wr_valid & wr_sel & ~occupied;
  assign full_n   = ~occupied;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      put_tok <= 1'b0;
    else if (accept) put_tok <= ~put_tok;
  end

  // word survives a partial reset; only the master reset clears it
  always_ff @(posedge clk or negedge data_rst_n) begin
    if (!data_rst_n) mbx_word <= '0;
    else if (accept) mbx_word <= wr_data;
  end
endmodule

// File: rtl/mbx_rd_side.sv
module mbx_rd_side #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [DATA_W-1:0] fifo_word,
  input  logic [DATA_W-1:0] mbx_word,
  input  logic              put_tok_async,
  output logic              full_n,
  output logic              ack_tok,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  import mbx_pkg::*;

  logic    put_seen;
  logic    occupied;
  logic    take;
  rd_src_e src;

  mbx_bit_sync #(.STAGES(SYNC_STAGES)) u_put_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (put_tok_async),
    .q    (put_seen)
  );

  assign occupied = tokens_pending(put_seen, ack_tok);
  assign full_n   = ~occupied;
  assign take     = rd_en & rd_sel & occupied;
  assign src      = rd_sel ? SRC_MBX : SRC_FIFO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ack_tok <= 1'b0;
    else if (take) ack_tok <= ~ack_tok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= (src == SRC_MBX) ? mbx_word : fifo_word;
    end
  end
endmodule

// File: rtl/mbx_mailbox_top.sv
module mbx_mailbox_top #(
  parameter int DATA_W      = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              wr_valid,
  input  logic              wr_mbx_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_full_n,
  input  logic              rd_en,
  input  logic              rd_mbx_sel,
  input  logic [DATA_W-1:0] fifo_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_data_valid,
  output logic              rd_full_n
);
  localparam int RST_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic              any_rst_n;
  logic              w_rst_n;
  logic              w_data_rst_n;
  logic              r_rst_n;
  logic              put_tok;
  logic              ack_tok;
  logic [DATA_W-1:0] mbx_word;

  assign any_rst_n = mrst_n & prst_n;

  mbx_rst_sync #(.STAGES(RST_STAGES)) u_wrst (
    .clk(clk_w), .arst_n(any_rst_n), .rst_n(w_rst_n)
  );
  mbx_rst_sync #(.STAGES(RST_STAGES)) u_wdrst (
    .clk(clk_w), .arst_n(mrst_n), .rst_n(w_data_rst_n)
  );
  mbx_rst_sync #(.STAGES(RST_STAGES)) u_rrst (
    .clk(clk_r), .arst_n(any_rst_n), .rst_n(r_rst_n)
  );

  mbx_wr_side #(.DATA_W(DATA_W), .SYNC_STAGES(RST_STAGES)) u_wr (
    .clk          (clk_w),
    .rst_n        (w_rst_n),
    .data_rst_n   (w_data_rst_n),
    .wr_valid     (wr_valid),
    .wr_sel       (wr_mbx_sel),
    .wr_data      (wr_data),
    .ack_tok_async(ack_tok),
    .full_n       (wr_full_n),
    .put_tok      (put_tok),
    .mbx_word     (mbx_word)
  );

  mbx_rd_side #(.DATA_W(DATA_W), .SYNC_STAGES(RST_STAGES)) u_rd (
    .clk          (clk_r),
    .rst_n        (r_rst_n),
    .rd_en        (rd_en),
    .rd_sel       (rd_mbx_sel),
    .fifo_word    (fifo_word),
    .mbx_word     (mbx_word),
    .put_tok_async(put_tok),
    .full_n       (rd_full_n),
    .ack_tok      (ack_tok),
    .rd_data      (rd_data),
    .rd_valid     (rd_data_valid)
  );
endmodule

// File: rtl/mbx_mailbox_chk.sv
module mbx_mailbox_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk_w,
  input logic              clk_r,
  input logic              w_rst_n,
  input logic              r_rst_n,
  input logic              wr_valid,
  input logic              wr_mbx_sel,
  input logic              wr_full_n,
  input logic              rd_en,
  input logic              rd_mbx_sel,
  input logic              rd_full_n,
  input logic [DATA_W-1:0] fifo_word,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_data_valid,
  input logic [DATA_W-1:0] mbx_word
);
  assert_write_fills_R1: assert property (@(posedge clk_w) disable iff (!w_rst_n)
    (wr_valid && wr_mbx_sel && wr_full_n) |=> !wr_full_n);

  assert_word_held_R2: assert property (@(posedge clk_w) disable iff (!w_rst_n)
    !wr_full_n |=> $stable(mbx_word));

  assert_read_empties_R3: assert property (@(posedge clk_r) disable iff (!r_rst_n)
    (rd_en && rd_mbx_sel && !rd_full_n) |=> rd_full_n);

  assert_fifo_path_R4: assert property (@(posedge clk_r) disable iff (!r_rst_n)
    (rd_en && !rd_mbx_sel) |=> (rd_data == $past(fifo_word)));

  assert_valid_tracks_R4: assert property (@(posedge clk_r) disable iff (!r_rst_n)
    rd_en |=> rd_data_valid);

  assert_valid_idle_R4: assert property (@(posedge clk_r) disable iff (!r_rst_n)
    !rd_en |=> !rd_data_valid);

  assert_reset_state_R6: assert property (@(posedge clk_r) disable iff (!r_rst_n)
    $rose(r_rst_n) |-> (rd_full_n && !rd_data_valid && rd_data == '0));
endmodule

bind mbx_mailbox_top mbx_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_w        (clk_w),
  .clk_r        (clk_r),
  .w_rst_n      (w_rst_n),
  .r_rst_n      (r_rst_n),
  .wr_valid     (wr_valid),
  .wr_mbx_sel   (wr_mbx_sel),
  .wr_full_n    (wr_full_n),
  .rd_en        (rd_en),
  .rd_mbx_sel   (rd_mbx_sel),
  .rd_full_n    (rd_full_n),
  .fifo_word    (fifo_word),
  .rd_data      (rd_data),
  .rd_data_valid(rd_data_valid),
  .mbx_word     (mbx_word)
);

// File: tb/tb_mbx_mailbox_top.sv
`timescale 1ns/1ps
module tb_mbx_mailbox_top;
  localparam int W = 36;

  logic         clk_w = 1'b0;
  logic         clk_r = 1'b0;
  logic         mrst_n = 1'b1;
  logic         prst_n = 1'b1;
  logic         wr_valid = 1'b0;
  logic         wr_mbx_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         wr_full_n;
  logic         rd_en = 1'b0;
  logic         rd_mbx_sel = 1'b0;
  logic [W-1:0] fifo_word = '0;
  logic [W-1:0] rd_data;
  logic         rd_data_valid;
  logic         rd_full_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  bit run = 1'b0;

  // reference model state
  logic [W-1:0] model_mbx = '0;
  logic [W-1:0] exp_data = '0;
  logic         exp_valid = 1'b0;

  always #2.0 clk_w = ~clk_w;   // 250 MHz
  always #3.5 clk_r = ~clk_r;   // unrelated reader clock

  mbx_mailbox_top #(.DATA_W(W)) dut (
    .clk_w(clk_w), .clk_r(clk_r), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_valid(wr_valid), .wr_mbx_sel(wr_mbx_sel), .wr_data(wr_data),
    .wr_full_n(wr_full_n), .rd_en(rd_en), .rd_mbx_sel(rd_mbx_sel),
    .fifo_word(fifo_word), .rd_data(rd_data), .rd_data_valid(rd_data_valid),
    .rd_full_n(rd_full_n)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model of the reader output register (R4, R6)
  always @(posedge clk_r or negedge mrst_n or negedge prst_n) begin
    if (!mrst_n || !prst_n) begin
      exp_valid <= 1'b0;
      exp_data  <= '0;
    end else begin
      exp_valid <= rd_en;
      if (rd_en) exp_data <= rd_mbx_sel ? model_mbx : fifo_word;
    end
  end

  always @(negedge clk_r) begin
    if (run && mrst_n && prst_n) begin
      chk(rd_data_valid == exp_valid, "R4 valid", W'(rd_data_valid), W'(exp_valid));
      chk(rd_data == exp_data, "R4 data", rd_data, exp_data);
    end
  end

  task automatic do_write(input logic [W-1:0] d, input logic sel, output bit took);
    @(negedge clk_w);
    wr_valid = 1'b1; wr_mbx_sel = sel; wr_data = d;
    took = wr_full_n && sel;
    @(negedge clk_w);
    wr_valid = 1'b0; wr_mbx_sel = 1'b0;
    if (took) model_mbx = d;
  endtask

  task automatic do_read(input logic sel);
    @(negedge clk_r);
    rd_en = 1'b1; rd_mbx_sel = sel;
    @(negedge clk_r);
    rd_en = 1'b0; rd_mbx_sel = 1'b0;
  endtask

  task automatic wait_rd_full(input string req);
    int n = 0;
    while (rd_full_n && n < 10) begin @(posedge clk_r); #0.1; n++; end
    chk(!rd_full_n && n <= 3, req, W'(n), W'(3));
  endtask

  task automatic wait_wr_free(input string req);
    int n = 0;
    while (!wr_full_n && n < 10) begin @(posedge clk_w); #0.1; n++; end
    chk(wr_full_n && n <= 3, req, W'(n), W'(3));
  endtask

  task automatic pulse_reset(input bit master);
    @(negedge clk_w);
    if (master) begin mrst_n = 1'b0; model_mbx = '0; end
    else prst_n = 1'b0;
    repeat (4) @(negedge clk_w);
    mrst_n = 1'b1; prst_n = 1'b1;
    repeat (4) @(negedge clk_r);
  endtask

  initial begin
    repeat (50000) @(posedge clk_w);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit took;
    #1 mrst_n = 1'b0;
    repeat (6) @(negedge clk_w);
    mrst_n = 1'b1;
    repeat (4) @(negedge clk_r);
    run = 1'b1;

    // R6: reset state
    chk(wr_full_n == 1'b1, "R6 wr_full_n", W'(wr_full_n), W'(1));
    chk(rd_full_n == 1'b1, "R6 rd_full_n", W'(rd_full_n), W'(1));
    chk(rd_data == '0, "R6 rd_data", rd_data, '0);
    chk(rd_data_valid == 1'b0, "R6 valid", W'(rd_data_valid), W'(0));

    // R1, R7: accepted write
    do_write(36'hA_1234_5678, 1'b1, took);
    chk(took && !wr_full_n, "R1 write fills", W'(wr_full_n), W'(0));
    wait_rd_full("R7 reader sees full");

    // R2: second write while full is dropped
    do_write(36'hB_BBBB_BBBB, 1'b1, took);
    chk(!took && !wr_full_n, "R2 blocked write", W'(wr_full_n), W'(0));

    // R3, R2: read returns first word, flag rises
    do_read(1'b1);
    chk(rd_data == 36'hA_1234_5678, "R2 first word kept", rd_data, 36'hA_1234_5678);
    chk(rd_full_n == 1'b1, "R3 read empties", W'(rd_full_n), W'(1));
    wait_wr_free("R7 writer sees empty");

    // R4: fifo path
    fifo_word = 36'hF_00F0_0F00;
    do_read(1'b0);
    chk(rd_data == 36'hF_00F0_0F00, "R4 fifo path", rd_data, 36'hF_00F0_0F00);

    // R2: write with select low ignored
    do_write(36'hC_CCCC_CCCC, 1'b0, took);
    chk(wr_full_n == 1'b1, "R2 sel low ignored", W'(wr_full_n), W'(1));

    // R5: stale read
    do_read(1'b1);
    chk(rd_data == 36'hA_1234_5678, "R5 stale word", rd_data, 36'hA_1234_5678);
    repeat (4) @(negedge clk_w);
    chk(wr_full_n && rd_full_n, "R5 flags stay high", W'({wr_full_n, rd_full_n}), W'(3));

    // R3: read with select low does not clear the flag
    do_write(36'hD_0000_000D, 1'b1, took);
    wait_rd_full("R7 reader sees full");
    fifo_word = 36'h1_2121_2121;
    do_read(1'b0);
    chk(rd_full_n == 1'b0, "R3 fifo read keeps flag", W'(rd_full_n), W'(0));
    do_read(1'b1);
    chk(rd_data == 36'hD_0000_000D, "R4 mailbox word", rd_data, 36'hD_0000_000D);
    wait_wr_free("R7 writer sees empty");

    // R8: partial reset while full keeps word
    do_write(36'hE_5555_AAAA, 1'b1, took);
    wait_rd_full("R7 reader sees full");
    pulse_reset(1'b0);
    chk(wr_full_n && rd_full_n, "R6 flags after partial", W'({wr_full_n, rd_full_n}), W'(3));
    chk(rd_data == '0, "R6 rd_data after partial", rd_data, '0);
    do_read(1'b1);
    chk(rd_data == 36'hE_5555_AAAA, "R8 word survives", rd_data, 36'hE_5555_AAAA);

    // R9: master reset clears word
    do_write(36'h7_7777_7777, 1'b1, took);
    wait_rd_full("R7 reader sees full");
    pulse_reset(1'b1);
    chk(wr_full_n && rd_full_n, "R6 flags after master", W'({wr_full_n, rd_full_n}), W'(3));
    do_read(1'b1);
    chk(rd_data == '0, "R9 word cleared", rd_data, '0);

    // several rounds with varied patterns
    for (int i = 0; i < 6; i++) begin
      logic [W-1:0] v;
      v = {4'(i), 32'h0F1E_2D3C ^ (32'h1111_1111 * i)};
      do_write(v, 1'b1, took);
      chk(took, "R1 round accept", W'(took), W'(1));
      wait_rd_full("R7 round reader full");
      do_read(1'b1);
      chk(rd_data == v, "R4 round data", rd_data, v);
      wait_wr_free("R7 round writer free");
    end

    repeat (3) @(negedge clk_r);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule